// File: doc/BRIEF.md
# Depthwise Activation Operand Selector

This block feeds the multiply stage of a three-tap depthwise convolution. It sees a window of nine 256-bit activation vectors, each made of eight 32-bit words, and a 32-bit command word. From the command it takes a 4-bit base code and a 2-bit stride-pattern code. The base code maps through a fixed, irregular table to a triple of vectors, called here the previous, centre and following vectors. The stride-pattern code then either passes the triple through unchanged or builds word-shifted operands that span the boundary between two neighbouring vectors.

The three aligned operands are registered once and leave the block with a valid strobe one clock after the command is presented. A command that carries the reserved pattern code raises an illegal flag instead of the valid strobe. The operand registers keep their last values, so nothing downstream accumulates. Multiplication, bias, accumulation and register-file access belong to other blocks.

Top module: `dw_operand_select`

## Requirements
- R1: Base code b in 0..6 (command bits [7:4]) selects vectors b, b+1 and b+2 as previous, centre and following.
- R2: Base code 7 selects vector 1 as previous, vector 0 as centre and vector 2 as following.
- R3: Base code b in 8..11 selects vector 2b-15 as previous, 2b-14 as centre and vector 0 as following (8 gives 1,2,0; 11 gives 7,8,0).
- R4: Base code b in 12..15 selects vector 2b-22 as previous, vector 0 as centre and vector 1 as following (12 gives 2,0,1; 15 gives 8,0,1).
- R5: Pattern code 0 (command bits [3:2]) presents previous, centre and following unchanged as operands 0, 1 and 2.
- R6: Pattern code 1 sets operand 0 to word 7 of previous followed by centre words 0..6. Operand 1 is the centre. Operand 2 is centre words 1..7 followed by word 0 of following. Operand word k occupies bits [32k+31:32k], and vector r of the window occupies bits [256r+255:256r] of the activation bus.
- R7: Pattern code 2 sets operand 0 to the previous vector. Operand 1 is previous words 1..7 followed by centre word 0. Operand 2 is previous words 2..7 followed by centre words 0 and 1.
- R8: Pattern code 3 raises the illegal flag one clock after the command, keeps the valid strobe low and leaves the operand outputs unchanged.
- R9: A legal command with the input valid high gives valid high, with the new operands, exactly one clock later. With the input valid low, the next cycle has valid and illegal low and the operands unchanged.
- R10: While reset is low, valid, illegal and all three operands are zero.
- R11: Command bits outside [7:2] have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command and window are presented this cycle |
| cmd | input | 32 | Command word; [7:4] base code, [3:2] pattern code |
| act_regs | input | 2304 | Nine activation vectors, vector r at [256r+255:256r] |
| out_valid | output | 1 | Operands are valid for accumulation |
| illegal | output | 1 | Previous command carried the reserved pattern code |
| op0 | output | 256 | Aligned operand for tap 0 |
| op1 | output | 256 | Aligned operand for tap 1 |
| op2 | output | 256 | Aligned operand for tap 2 |

## Verification
The hardest case to reach from the ports is a base code whose triple wraps onto the low vectors (codes 7 and 12..15) combined with a shifted pattern. In that case, a boundary word taken from the wrong neighbour looks the same as a correct one unless every word in the window is distinct. The stimulus therefore fills each of the nine vectors with words that encode both the vector and word position. It then sweeps all sixteen base codes against all three legal patterns, each back to back with the next. An illegal command and an idle cycle follow a legal one, so that the hold of the operand registers can be seen.

// File: rtl/dw_sel_pkg.sv
package dw_sel_pkg;
   typedef enum logic [1:0] {
      PAT_DENSE = 2'd0,
      PAT_EDGE  = 2'd1,
      PAT_LEAD  = 2'd2,
      PAT_RSVD  = 2'd3
   } pattern_e;

   localparam int BASE_LSB  = 4;
   localparam int BASE_W    = 4;
   localparam int PAT_LSB   = 2;
   localparam int PAT_W     = 2;
   localparam int TAPS      = 3;
   localparam int MIN_REGS  = 9;
endpackage

// File: rtl/dw_base_decode.sv
module dw_base_decode
   import dw_sel_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic [BASE_W-1:0] code,
   output logic [IDX_W-1:0]  idx_prev,
   output logic [IDX_W-1:0]  idx_cent,
   output logic [IDX_W-1:0]  idx_next
);
   logic [5:0] twice;
   logic [5:0] p_raw, c_raw, n_raw;

   assign twice = {1'b0, code, 1'b0};

   always_comb begin
      p_raw = 6'd0;
      c_raw = 6'd0;
      n_raw = 6'd0;
      if (code <= 4'd6) begin
         p_raw = {2'b00, code};
         c_raw = {2'b00, code} + 6'd1;
         n_raw = {2'b00, code} + 6'd2;
      end else if (code == 4'd7) begin
         p_raw = 6'd1;
         c_raw = 6'd0;
         n_raw = 6'd2;
      end else if (code <= 4'd11) begin
         p_raw = twice - 6'd15;
         c_raw = twice - 6'd14;
         n_raw = 6'd0;
      end else begin
         p_raw = twice - 6'd22;
         c_raw = 6'd0;
         n_raw = 6'd1;
      end
   end

   assign idx_prev = IDX_W'(p_raw);
   assign idx_cent = IDX_W'(c_raw);
   assign idx_next = IDX_W'(n_raw);
endmodule

// File: rtl/dw_word_align.sv
module dw_word_align
   import dw_sel_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WORDS  = 8
) (
   input  pattern_e                  pattern,
   input  logic [WORDS*WORD_W-1:0]   v_prev,
   input  logic [WORDS*WORD_W-1:0]   v_cent,
   input  logic [WORDS*WORD_W-1:0]   v_next,
   output logic [WORDS*WORD_W-1:0]   o0,
   output logic [WORDS*WORD_W-1:0]   o1,
   output logic [WORDS*WORD_W-1:0]   o2
);
   localparam int VW = WORDS * WORD_W;

   logic [VW-1:0] edge_o0, edge_o2, lead_o1, lead_o2;

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      if (k == 0) begin : g_e0_wrap
         assign edge_o0[k*WORD_W +: WORD_W] = v_prev[(WORDS-1)*WORD_W +: WORD_W];
      end else begin : g_e0_body
         assign edge_o0[k*WORD_W +: WORD_W] = v_cent[(k-1)*WORD_W +: WORD_W];
      end

      if (k == WORDS-1) begin : g_e2_wrap
         assign edge_o2[k*WORD_W +: WORD_W] = v_next[0 +: WORD_W];
      end else begin : g_e2_body
         assign edge_o2[k*WORD_W +: WORD_W] = v_cent[(k+1)*WORD_W +: WORD_W];
      end

      if (k < WORDS-1) begin : g_l1_body
         assign lead_o1[k*WORD_W +: WORD_W] = v_prev[(k+1)*WORD_W +: WORD_W];
      end else begin : g_l1_wrap
         assign lead_o1[k*WORD_W +: WORD_W] = v_cent[0 +: WORD_W];
      end

      if (k < WORDS-2) begin : g_l2_body
         assign lead_o2[k*WORD_W +: WORD_W] = v_prev[(k+2)*WORD_W +: WORD_W];
      end else begin : g_l2_wrap
         assign lead_o2[k*WORD_W +: WORD_W] = v_cent[(k-(WORDS-2))*WORD_W +: WORD_W];
      end
   end

   always_comb begin
      unique case (pattern)
         PAT_DENSE: begin o0 = v_prev;  o1 = v_cent;  o2 = v_next;  end
         PAT_EDGE:  begin o0 = edge_o0; o1 = v_cent;  o2 = edge_o2; end
         PAT_LEAD:  begin o0 = v_prev;  o1 = lead_o1; o2 = lead_o2; end
         default:   begin o0 = '0;      o1 = '0;      o2 = '0;      end
      endcase
   end
endmodule

// File: rtl/dw_operand_select.sv
module dw_operand_select
   import dw_sel_pkg::*;
#(
   parameter int VEC_W    = 256,
   parameter int WORD_W   = 32,
   parameter int NUM_REGS = 9,
   parameter int CMD_W    = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [CMD_W-1:0]          cmd,
   input  logic [NUM_REGS*VEC_W-1:0] act_regs,
   output logic                      out_valid,
   output logic                      illegal,
   output logic [VEC_W-1:0]          op0,
   output logic [VEC_W-1:0]          op1,
   output logic [VEC_W-1:0]          op2
);
   localparam int WORDS = VEC_W / WORD_W;
   localparam int IDX_W = $clog2(NUM_REGS);

   if (VEC_W % WORD_W != 0) begin : g_bad_word
      $error("VEC_W must be a multiple of WORD_W");
   end
   if (WORDS < 3) begin : g_bad_words
      $error("at least three words per vector are needed");
   end
   if (NUM_REGS < MIN_REGS) begin : g_bad_regs
      $error("the base table reaches vector 8");
   end
   if (CMD_W < BASE_LSB + BASE_W) begin : g_bad_cmd
      $error("command word too narrow");
   end

   logic [BASE_W-1:0] base_code;
   pattern_e          pattern;
   logic              cmd_ok;
   logic [IDX_W-1:0]  idx [TAPS];
   logic [VEC_W-1:0]  pick [TAPS];
   logic [VEC_W-1:0]  al0, al1, al2;

   assign base_code = cmd[BASE_LSB +: BASE_W];
   assign pattern   = pattern_e'(cmd[PAT_LSB +: PAT_W]);
   assign cmd_ok    = (pattern != PAT_RSVD);

   dw_base_decode #(.IDX_W(IDX_W)) u_dec (
      .code     (base_code),
      .idx_prev (idx[0]),
      .idx_cent (idx[1]),
      .idx_next (idx[2])
   );

   for (genvar t = 0; t < TAPS; t++) begin : g_pick
      assign pick[t] = act_regs[idx[t]*VEC_W +: VEC_W];
   end

   dw_word_align #(.WORD_W(WORD_W), .WORDS(WORDS)) u_align (
      .pattern (pattern),
      .v_prev  (pick[0]),
      .v_cent  (pick[1]),
      .v_next  (pick[2]),
      .o0      (al0),
      .o1      (al1),
      .o2      (al2)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         op0       <= '0;
         op1       <= '0;
         op2       <= '0;
      end else begin
         out_valid <= in_valid && cmd_ok;
         illegal   <= in_valid && !cmd_ok;
         if (in_valid && cmd_ok) begin
            op0 <= al0;
            op1 <= al1;
            op2 <= al2;
         end
      end
   end
endmodule

// File: rtl/dw_operand_select_chk.sv
module dw_operand_select_chk #(
   parameter int VEC_W    = 256,
   parameter int NUM_REGS = 9,
   parameter int CMD_W    = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [CMD_W-1:0]          cmd,
   input logic [NUM_REGS*VEC_W-1:0] act_regs,
   input logic                      out_valid,
   input logic                      illegal,
   input logic [VEC_W-1:0]          op0,
   input logic [VEC_W-1:0]          op1,
   input logic [VEC_W-1:0]          op2
);
   a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && illegal));

   a_r8_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmd[3:2] == 2'd3) |=> (illegal && !out_valid));

   a_r8_ops_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmd[3:2] == 2'd3) |=> ($stable(op0) && $stable(op1) && $stable(op2)));

   a_r9_legal_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmd[3:2] != 2'd3) |=> (out_valid && !illegal));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !illegal && $stable(op1)));

   a_r5_base0_dense: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmd[7:2] == 6'd0) |=>
         (op0 == $past(act_regs[0 +: VEC_W]) && op1 == $past(act_regs[VEC_W +: VEC_W])
          && op2 == $past(act_regs[2*VEC_W +: VEC_W])));

   a_r6_centre_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cmd[7:2] == 6'd1) |=> (op1 == $past(act_regs[VEC_W +: VEC_W])));
endmodule

bind dw_operand_select dw_operand_select_chk #(
   .VEC_W    (VEC_W),
   .NUM_REGS (NUM_REGS),
   .CMD_W    (CMD_W)
) u_chk (.*);

// File: tb/dw_operand_select_test.sv
module dw_operand_select_test;
   localparam int VW = 256;
   localparam int NR = 9;
   localparam int WN = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [31:0]     cmd = '0;
   logic [NR*VW-1:0] act = '0;
   logic            out_valid, illegal;
   logic [VW-1:0]   op0, op1, op2;

   logic [31:0]     rw [NR][WN];
   logic [VW-1:0]   e_op [3];
   logic            e_v, e_ill;
   int              n_cmp = 0;
   int              n_bad = 0;

   always #10 clk = ~clk;

   dw_operand_select uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cmd(cmd), .act_regs(act),
      .out_valid(out_valid), .illegal(illegal), .op0(op0), .op1(op1), .op2(op2)
   );

   task automatic fill_window(input int seed);
      for (int r = 0; r < NR; r++) begin
         for (int k = 0; k < WN; k++) begin
            rw[r][k] = 32'((r + 1) * 32'h1000_0000) + 32'(k * 32'h0011_0000) + 32'(seed * 7 + r * 3 + k);
            act[r*VW + k*32 +: 32] = rw[r][k];
         end
      end
   endtask

   task automatic triple(input int b, output int p, output int c, output int n);
      if (b < 7) begin p = b; c = b + 1; n = b + 2; end
      else if (b == 7) begin p = 1; c = 0; n = 2; end
      else if (b < 12) begin p = 2*b - 15; c = p + 1; n = 0; end
      else begin p = 2*b - 22; c = 0; n = 1; end
   endtask

   task automatic model(input logic v, input logic [31:0] c);
      int pat, p, m, n;
      logic [31:0] ow [3][WN];
      if (!v) begin
         e_v = 1'b0; e_ill = 1'b0;
      end else begin
         pat = int'(c[3:2]);
         if (pat == 3) begin
            e_v = 1'b0; e_ill = 1'b1;
         end else begin
            e_v = 1'b1; e_ill = 1'b0;
            triple(int'(c[7:4]), p, m, n);
            for (int k = 0; k < WN; k++) begin
               if (pat == 0) begin
                  ow[0][k] = rw[p][k]; ow[1][k] = rw[m][k]; ow[2][k] = rw[n][k];
               end else if (pat == 1) begin
                  ow[0][k] = (k == 0) ? rw[p][WN-1] : rw[m][k-1];
                  ow[1][k] = rw[m][k];
                  ow[2][k] = (k == WN-1) ? rw[n][0] : rw[m][k+1];
               end else begin
                  ow[0][k] = rw[p][k];
                  ow[1][k] = (k < WN-1) ? rw[p][k+1] : rw[m][0];
                  ow[2][k] = (k < WN-2) ? rw[p][k+2] : rw[m][k-(WN-2)];
               end
            end
            for (int t = 0; t < 3; t++)
               for (int k = 0; k < WN; k++)
                  e_op[t][k*32 +: 32] = ow[t][k];
         end
      end
   endtask

   task automatic compare(input string tag);
      n_cmp++;
      if (out_valid !== e_v || illegal !== e_ill || op0 !== e_op[0] ||
          op1 !== e_op[1] || op2 !== e_op[2]) begin
         n_bad++;
         $display("FAIL %s: got v=%b ill=%b op0=%h op1=%h op2=%h | exp v=%b ill=%b op0=%h op1=%h op2=%h",
                  tag, out_valid, illegal, op0, op1, op2, e_v, e_ill, e_op[0], e_op[1], e_op[2]);
      end
   endtask

   task automatic step(input logic v, input logic [31:0] c, input string tag);
      in_valid = v;
      cmd      = c;
      model(v, c);
      @(negedge clk);
      compare(tag);
   endtask

   function automatic string base_tag(input int b);
      if (b < 7) return "R1";
      if (b == 7) return "R2";
      if (b < 12) return "R3";
      return "R4";
   endfunction

   initial begin
      #(20 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got no finish, exp finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      string ptag [3];
      ptag[0] = "R5"; ptag[1] = "R6"; ptag[2] = "R7";
      e_v = 1'b0; e_ill = 1'b0;
      for (int t = 0; t < 3; t++) e_op[t] = '0;
      fill_window(1);
      in_valid = 1'b1;
      cmd = 32'h0000_0014;
      repeat (3) @(negedge clk);
      compare("R10 reset");
      rst_n = 1'b1;
      in_valid = 1'b0;

      // R9: first legal command after reset appears exactly one clock later
      step(1'b1, 32'h0000_0000, "R9 first after reset +R1+R5");

      for (int pat = 0; pat < 3; pat++) begin
         for (int b = 0; b < 16; b++) begin
            fill_window(b + 16*pat);
            step(1'b1, {24'h0, 4'(b), 2'(pat), 2'b00},
                 {base_tag(b), "+", ptag[pat], $sformatf(" base=%0d", b)});
         end
      end

      // R8: reserved pattern after a legal one; operands held
      step(1'b1, 32'h0000_0094, "R3+R6 before reserved");
      fill_window(77);
      step(1'b1, 32'h0000_009C, "R8 reserved pattern");
      step(1'b1, 32'h0000_00FC, "R8 reserved again");

      // R9: idle cycles with changing command and window
      fill_window(91);
      step(1'b0, 32'h0000_0028, "R9 idle hold");
      step(1'b0, 32'hFFFF_FFFF, "R9 idle with garbage");

      // R11: random bits outside [7:2]
      for (int i = 0; i < 24; i++) begin
         logic [31:0] rc;
         rc = $urandom;
         if (rc[3:2] == 2'd3) rc[3:2] = 2'd1;
         fill_window(200 + i);
         step(1'b1, rc, "R11 upper and low bits ignored");
      end

      // back-to-back wrap cases with shifted patterns
      fill_window(300);
      step(1'b1, 32'hA5A5_A5F4, "R4+R6 wrap code 15");
      step(1'b1, 32'h5A5A_5A78, "R2+R7 code 7");
      step(1'b1, 32'h0000_00C8, "R4+R7 code 12");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule